// File: doc/BRIEF.md
# Single-Shot Oscillator Trim Controller

This controller trims a low-power on-chip oscillator in one pass. The oscillator clocks the block itself. While a reference-window input is high, the block counts its own clock edges. The length of that window is known: 133.3 µs in the intended use. The target frequency is 320 kHz, so a perfectly tuned oscillator gives 43 edges in the window.

The count is compared with two thresholds. The upper one is 43. The lower one sits 32 below it, at 11. From that comparison the block chooses one of three outcomes:
- Add current through a 5-bit additive trim code.
- Remove current through a 5-bit subtractive trim code.
- Flag that the oscillator is too slow to reach the target.

While the window is open, the additive units are held off and the subtractive units are held on. This state stays fixed until counting is over, because any change to the oscillator during the count would spoil the measurement. The new codes are applied together one cycle after the window closes. A done pulse marks that moment, and the codes then hold until the next window.

All pins are plain control and status signals. There is no streamed data interface, so no valid/ready handshake is used.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset, before any window, add_dis_o = 00000, sub_cut_o = 00000, under_o = 0 and done_o = 0, so every current unit is on.
- R2: On the first clock edge at which win_i is sampled high after being low, add_dis_o becomes 11111 and sub_cut_o becomes 00000, and under_o clears.
- R3: The edge count D0 is the number of clock edges at which win_i is sampled high in one window. It saturates at the counter maximum and never wraps.
- R4: If D0 <= 11 when the window closes, under_o = 1, add_dis_o = 00000 and sub_cut_o = 00000.
- R5: If 11 < D0 < 43, add_dis_o = D0 - 12 as a binary value, and sub_cut_o = 0. add_dis_o is a binary count of disabled additive units out of 31, so the number of enabled units is 32 - (D0 - 11).
- R6: If D0 >= 43, add_dis_o = 11111 and sub_cut_o = min(D0 - 43, 31) as a binary value. For example, D0 = 45 gives sub_cut_o = 00010.
- R7: add_dis_o and sub_cut_o do not change on any clock edge at which win_i is sampled high for the second or later time in the same window.
- R8: The result codes and under_o take effect on the first edge at which win_i is sampled low after a window. done_o is high for exactly that one cycle. The outputs then hold until the next window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being trimmed |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_i | input | 1 | Reference window; edges are counted while it is high |
| add_dis_o | output | 5 | Additive trim: binary count of disabled add units |
| sub_cut_o | output | 5 | Subtractive trim: binary count of removed units |
| under_o | output | 1 | Oscillator below the calibratable range |
| done_o | output | 1 | One-cycle pulse when the new trim is applied |

## Verification
The hardest conditions to reach are the exact threshold boundaries: counts of 11, 12, 42, 43 and 74, 75. These are where the decision switches branch or the subtractive code saturates. The hardest condition of all is a count large enough to saturate the counter.

The bench reaches them with directed windows of exactly those lengths, including one longer than the counter range. These are mixed with random window lengths and random idle gaps drawn from a fixed seed. A final run of back-to-back windows confirms that a new window forces the held codes back to the counting state.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef struct packed {
    logic       under;
    logic [4:0] add_dis;
    logic [4:0] sub_cut;
  } trim_code_t;
endpackage

// File: rtl/trim_edge_counter.sv
module trim_edge_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_o <= '0;
    else if (start_i)                   cnt_o <= {{(CNT_W-1){1'b0}}, 1'b1};
    else if (run_i && cnt_o != CntMax)  cnt_o <= cnt_o + 1'b1;
  end

  // R3: the count never wraps while the window stays open
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i) |=> (cnt_o >= $past(cnt_o)));
endmodule

// File: rtl/trim_code_map.sv
module trim_code_map
  import trim_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int UNIT_W = 5,
  parameter int K_HI   = 43
) (
  input  logic [CNT_W-1:0] cnt_i,
  output trim_code_t       code_o
);
  localparam int K_LO  = K_HI - (1 << UNIT_W);
  localparam int UMAX  = (1 << UNIT_W) - 1;

  int unsigned cnt_u;
  int unsigned diff;

  always_comb begin
    cnt_u  = int'(cnt_i);
    diff   = 0;
    code_o = '0;
    if (cnt_u <= K_LO) begin
      code_o.under = 1'b1;
    end else if (cnt_u < K_HI) begin
      diff           = cnt_u - K_LO - 1;
      code_o.add_dis = UNIT_W'(diff);
    end else begin
      diff           = cnt_u - K_HI;
      code_o.add_dis = UNIT_W'(UMAX);
      code_o.sub_cut = (diff > UMAX) ? UNIT_W'(UMAX) : UNIT_W'(diff);
    end
  end

  // R4/R5/R6: the three outcomes never mix
  always_comb begin
    a_r6_excl: assert (!(code_o.sub_cut != '0 && code_o.add_dis != UNIT_W'(UMAX)));
    a_r4_under_clean: assert (!code_o.under || (code_o.add_dis == '0 && code_o.sub_cut == '0));
  end
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import trim_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int UNIT_W = 5,
  parameter int K_HI   = 43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_i,
  output logic [UNIT_W-1:0] add_dis_o,
  output logic [UNIT_W-1:0] sub_cut_o,
  output logic              under_o,
  output logic              done_o
);
  logic             win_q;
  logic             win_rise, win_fall;
  logic [CNT_W-1:0] cnt;
  trim_code_t       code;

  assign win_rise = win_i && !win_q;
  assign win_fall = !win_i && win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_i;
  end

  trim_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start_i(win_rise), .run_i(win_i), .cnt_o(cnt)
  );

  trim_code_map #(.CNT_W(CNT_W), .UNIT_W(UNIT_W), .K_HI(K_HI)) u_map (
    .cnt_i(cnt), .code_o(code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      add_dis_o <= '0;
      sub_cut_o <= '0;
      under_o   <= 1'b0;
      done_o    <= 1'b0;
    end else if (win_rise) begin
      add_dis_o <= '1;
      sub_cut_o <= '0;
      under_o   <= 1'b0;
      done_o    <= 1'b0;
    end else if (win_fall) begin
      add_dis_o <= code.add_dis;
      sub_cut_o <= code.sub_cut;
      under_o   <= code.under;
      done_o    <= 1'b1;
    end else begin
      done_o    <= 1'b0;
    end
  end

  // R2: window start forces the counting state
  a_r2_force_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    win_rise |=> (add_dis_o == '1 && sub_cut_o == '0 && !under_o));
  // R7: trim codes frozen inside the window
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (win_i && win_q) |=> ($stable(add_dis_o) && $stable(sub_cut_o)));
  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8: outputs hold while idle
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_i && !win_q) |=> ($stable(add_dis_o) && $stable(sub_cut_o) && $stable(under_o)));
endmodule

// File: tb/test_osc_trim_ctrl.sv
module test_osc_trim_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       win_i = 1'b0;
  logic [4:0] add_dis_o, sub_cut_o;
  logic       under_o, done_o;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  osc_trim_ctrl i_osc_trim_ctrl (
    .clk(clk), .rst_n(rst_n), .win_i(win_i),
    .add_dis_o(add_dis_o), .sub_cut_o(sub_cut_o),
    .under_o(under_o), .done_o(done_o)
  );

  function automatic logic [11:0] expect_code(int d0);
    int d;
    d = (d0 > 255) ? 255 : d0;            // R3 saturation
    if (d <= 11)      return {1'b1, 1'b0, 5'd0, 5'd0};               // R4
    else if (d < 43)  return {1'b0, 1'b0, 5'(d - 12), 5'd0};         // R5
    else              return {1'b0, 1'b0, 5'd31, 5'((d - 43 > 31) ? 31 : d - 43)}; // R6
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (under,done,add,sub)", req, act, exp);
    end
  endtask

  function automatic logic [11:0] outs();
    return {under_o, done_o, add_dis_o, sub_cut_o};
  endfunction

  task automatic run_window(int n, int gap);
    logic [11:0] e;
    logic [11:0] held;
    win_i = 1'b1;
    @(negedge clk);
    check("R2", outs(), {1'b0, 1'b0, 5'd31, 5'd0});
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      check("R7", outs(), {1'b0, 1'b0, 5'd31, 5'd0});
    end
    win_i = 1'b0;
    @(negedge clk);
    e = expect_code(n);
    e[10] = 1'b1;
    check($sformatf("R8/R3 d0=%0d", n), outs(), e);
    e[10] = 1'b0;
    held = e;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R8 hold", outs(), held);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1", outs(), 12'h000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", outs(), 12'h000);
    run_window(45, 2);   // R6 example: sub 00010
    run_window(11, 2);   // R4 boundary
    run_window(12, 2);   // R5 lower edge
    run_window(42, 2);   // R5 upper edge
    run_window(43, 2);   // R6 exact target
    run_window(74, 2);   // R6 last unsaturated
    run_window(75, 2);   // R6 saturation
    run_window(1, 2);    // R4 minimum
    run_window(300, 2);  // R3 counter saturation
    run_window(30, 1);
    run_window(20, 1);   // R2 after a held result
    for (int k = 0; k < 40; k++)
      run_window(1 + int'($urandom_range(0, 99)), int'($urandom_range(1, 5)));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule